// File: doc/BRIEF.md
# PHY Management Register Bridge

This block turns a single 32-bit register write into a complete serial management transaction towards an external PHY. Software writes the register once with a 5-bit PHY register number, a direction flag and, for a PHY write, 16 bits of data. The bridge then produces the management clock and shifts out the whole frame. For a read, it releases the data line during the turnaround and data phases and samples what the PHY returns.

Completion is shown by the flag bit, which moves in a different direction for each command. A write command starts with the flag at one, and the flag drops to zero when the frame ends. A read command starts with the flag at zero, and the flag rises to one once the returned data sits in the low 16 bits. Software polls the register until it sees the expected flag value. The frame takes 128 × `CLK_DIV` system clocks, which is far inside any polling budget of several milliseconds. The PHY address field in the frame is fixed by a parameter (default 1). Any register write that arrives while a frame is running is dropped.

The frame engine is a state machine with these states:
- `ST_IDLE`: waiting for a command.
- `ST_PRE`: preamble of ones.
- `ST_SOF`: start code.
- `ST_OP`: opcode.
- `ST_PHY`: PHY address.
- `ST_REG`: register address.
- `ST_TA`: turnaround.
- `ST_DATA`: 16 data bits.

The transitions are:
- IDLE→PRE when a write is accepted.
- Each later state moves to the next one on the falling MDC edge that ends its last bit.
- DATA→IDLE on the falling edge that ends bit 63, which also completes the register update.

Top module: `mdio_reg_bridge`

## Requirements
- R1: The register reads as data in bits 15:0, the PHY register number in bits 20:16 and the flag in bit 31. Every other bit reads zero, whatever value was written to it.
- R2: A write with bit 31 = 1 starts a PHY write of bits 15:0. The flag reads 1 from the clock after acceptance until the frame ends, then reads 0. Bits 20:0 keep the written value.
- R3: A write with bit 31 = 0 starts a PHY read. When the frame ends, bits 15:0 hold the 16 bits sampled from the PHY (first sampled bit in bit 15), the flag reads 1, and bits 20:16 keep the register number.
- R4: The frame is sent most significant bit first, one bit per MDC period, with MDIO changing only when MDC falls. Its content, in order, is:
  - 32 ones;
  - start code 0,1;
  - opcode 1,0 for a read or 0,1 for a write;
  - PHY address 00001;
  - the 5-bit register number;
  - turnaround 1,0 for a write;
  - 16 data bits.
- R5: During a read, mdio_oe is 0 for the last 18 bits (turnaround and data). The PHY data bit is sampled on the system clock edge at which MDC rises.
- R6: MDC is low while idle. During a frame, each MDC half period lasts `CLK_DIV` clocks and MDC is high in the second half of every bit. The register update happens exactly 128 × `CLK_DIV` clocks after the accepting edge.
- R7: A register write that arrives while a frame is running is ignored, including one on the very edge at which the frame completes. A write one clock later is accepted.
- R8: After reset, rd_data is 0, MDC is 0, mdio_oe is 0 and mdio_out is 0.
- R9: mdio_out is 0 whenever mdio_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one clock |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register value |
| mdio_in | input | 1 | Data line as seen from the pad |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |

## Verification
Two events can fall in the same cycle: the end of a frame, which updates the register, and a new register write. The bench provokes this by raising wr_en on exactly the completion edge, as counted by its own reference model. It then raises wr_en again one clock later. The first write must leave no trace in rd_data or on MDC, and the second must start a fresh frame whose fields and timing the per-cycle model predicts. A write placed in the middle of a read frame is judged the same way, against the final read result.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    localparam logic [1:0] SOF_CODE  = 2'b01;
    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] TA_WRITE  = 2'b10;
    localparam logic [1:0] TA_READ   = 2'b00;

endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wrap = run && (cnt_q == CNT_LAST);
    assign rise = wrap && !mdc_q;
    assign fall = wrap && mdc_q;
    assign mdc  = mdc_q;

    assert_edge_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int PHY_AW   = 5,
    parameter int REG_AW   = 5,
    parameter int DATA_W   = 16,
    parameter int PHY_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_read,
    input  logic [REG_AW-1:0] start_reg,
    input  logic [DATA_W-1:0] start_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdc,
    input  logic              mdio_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_capture,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int IW         = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] END_PRE  = IW'(PRE_BITS - 1);
    localparam logic [IW-1:0] END_SOF  = IW'(PRE_BITS + 1);
    localparam logic [IW-1:0] END_OP   = IW'(PRE_BITS + 3);
    localparam logic [IW-1:0] END_PHY  = IW'(PRE_BITS + 3 + PHY_AW);
    localparam logic [IW-1:0] END_REG  = IW'(PRE_BITS + 3 + PHY_AW + REG_AW);
    localparam logic [IW-1:0] END_TA   = IW'(PRE_BITS + 5 + PHY_AW + REG_AW);
    localparam logic [IW-1:0] END_DATA = IW'(FRAME_BITS - 1);

    mdio_state_e            state_q, state_d;
    logic [IW-1:0]          bit_q;
    logic [FRAME_BITS-1:0]  frame_q;
    logic                   is_read_q;
    logic [DATA_W-1:0]      cap_q;
    logic                   bit_end;

    function automatic logic at_end(input logic [IW-1:0] idx, input logic [IW-1:0] last);
        return idx == last;
    endfunction

    assign bit_end = fall;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                              state_d = ST_PRE;
            ST_PRE:  if (bit_end && at_end(bit_q, END_PRE))  state_d = ST_SOF;
            ST_SOF:  if (bit_end && at_end(bit_q, END_SOF))  state_d = ST_OP;
            ST_OP:   if (bit_end && at_end(bit_q, END_OP))   state_d = ST_PHY;
            ST_PHY:  if (bit_end && at_end(bit_q, END_PHY))  state_d = ST_REG;
            ST_REG:  if (bit_end && at_end(bit_q, END_REG))  state_d = ST_TA;
            ST_TA:   if (bit_end && at_end(bit_q, END_TA))   state_d = ST_DATA;
            ST_DATA: if (bit_end && at_end(bit_q, END_DATA)) state_d = ST_IDLE;
            default:                                         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame shifter, bit counter, read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q     <= '0;
            frame_q   <= '0;
            is_read_q <= 1'b0;
            cap_q     <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                bit_q     <= '0;
                is_read_q <= start_read;
                cap_q     <= '0;
                frame_q   <= {{PRE_BITS{1'b1}}, SOF_CODE,
                              start_read ? OP_READ : OP_WRITE,
                              PHY_AW'(PHY_ADDR), start_reg,
                              start_read ? TA_READ : TA_WRITE,
                              start_read ? {DATA_W{1'b0}} : start_data};
            end
        end else begin
            if (rise && is_read_q && state_q == ST_DATA)
                cap_q <= {cap_q[DATA_W-2:0], mdio_in};
            if (fall) begin
                bit_q   <= bit_q + 1'b1;
                frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:        mdio_oe = 1'b0;
            ST_TA, ST_DATA: mdio_oe = !is_read_q;
            default:        mdio_oe = 1'b1;
        endcase
        mdio_out = mdio_oe & frame_q[FRAME_BITS-1];
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_DATA) && bit_end && at_end(bit_q, END_DATA);
    assign rd_capture = cap_q;

    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read_q && (state_q == ST_DATA || state_q == ST_TA)) |-> !mdio_oe);

    assert_idle_mdc_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mdc);

    assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mdio_oe);

    assert_done_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE));

endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge #(
    parameter int CLK_DIV  = 20,
    parameter int REG_W    = 32,
    parameter int DATA_W   = 16,
    parameter int REG_AW   = 5,
    parameter int PHY_AW   = 5,
    parameter int PHY_ADDR = 1,
    parameter int PRE_BITS = 32,
    parameter int ADDR_LSB = 16,
    parameter int FLAG_POS = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             mdio_in,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe
);
    logic              busy, done, accept;
    logic              rise, fall;
    logic [DATA_W-1:0] rd_capture;
    logic [DATA_W-1:0] data_q;
    logic [REG_AW-1:0] addr_q;
    logic              flag_q;
    logic              unused_wr;

    assign accept    = wr_en && !busy;
    assign unused_wr = ^wr_data;

    mdc_tick_gen #(
        .HALF_DIV (CLK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_frame_fsm #(
        .PRE_BITS (PRE_BITS),
        .PHY_AW   (PHY_AW),
        .REG_AW   (REG_AW),
        .DATA_W   (DATA_W),
        .PHY_ADDR (PHY_ADDR)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_read (!wr_data[FLAG_POS]),
        .start_reg  (wr_data[ADDR_LSB +: REG_AW]),
        .start_data (wr_data[DATA_W-1:0]),
        .rise       (rise),
        .fall       (fall),
        .mdc        (mdc),
        .mdio_in    (mdio_in),
        .busy       (busy),
        .done       (done),
        .rd_capture (rd_capture),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            addr_q <= '0;
            flag_q <= 1'b0;
        end else if (accept) begin
            data_q <= wr_data[DATA_W-1:0];
            addr_q <= wr_data[ADDR_LSB +: REG_AW];
            flag_q <= wr_data[FLAG_POS];
        end else if (done) begin
            if (!flag_q) begin
                data_q <= rd_capture;
                flag_q <= 1'b1;
            end else begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[DATA_W-1:0]         = data_q;
        rd_data[ADDR_LSB +: REG_AW] = addr_q;
        rd_data[FLAG_POS]           = flag_q;
    end

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(rd_data));

    assert_write_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_q) |=> !rd_data[FLAG_POS]);

    assert_read_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flag_q) |=> rd_data[FLAG_POS]);

    assert_addr_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(rd_data[ADDR_LSB +: REG_AW]));

endmodule

// File: tb/mdio_reg_bridge_test.sv
module mdio_reg_bridge_test;
    localparam int H     = 20;
    localparam int FBITS = 64;
    localparam int FLEN  = FBITS * 2 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mdio_in = 1'b1;
    logic        mdc, mdio_out, mdio_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    mdio_reg_bridge #(.CLK_DIV(H)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .mdio_in  (mdio_in),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    bit          m_busy = 0;
    bit          m_isread = 0;
    int          m_k = 0;
    logic [31:0] m_reg = '0;
    bit          m_bits[$];
    logic [15:0] phy_val = 16'h0000;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_reg = '0;
        end else if (m_busy) begin
            m_k++;
            if (m_k == FLEN) begin
                m_busy = 0;
                if (m_isread) m_reg = {1'b1, 10'b0, m_reg[20:16], phy_val};
                else          m_reg[31] = 1'b0;
            end
        end else if (wr_en) begin
            m_reg    = wr_data & 32'h801F_FFFF;
            m_isread = !wr_data[31];
            m_busy   = 1;
            m_k      = 0;
            m_bits.delete();
            for (int i = 0; i < 32; i++) m_bits.push_back(1'b1);
            m_bits.push_back(1'b0); m_bits.push_back(1'b1);
            m_bits.push_back(m_isread); m_bits.push_back(!m_isread);
            for (int i = 4; i >= 0; i--) m_bits.push_back(i == 0);
            for (int i = 20; i >= 16; i--) m_bits.push_back(wr_data[i]);
            m_bits.push_back(!m_isread); m_bits.push_back(1'b0);
            for (int i = 15; i >= 0; i--) m_bits.push_back(m_isread ? 1'b0 : wr_data[i]);
        end
    end

    // per-cycle compare and PHY model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_mdc, e_oe, e_out;
            int b;
            b = m_k / (2 * H);
            if (!m_busy) begin
                e_mdc = 0; e_oe = 0; e_out = 0;
            end else begin
                e_mdc = ((m_k / H) % 2) == 1;
                e_oe  = !(m_isread && b >= 46);
                e_out = e_oe ? m_bits[b] : 1'b0;
            end
            chk(rd_data === m_reg, "R1/R2/R3 rd_data", rd_data, m_reg);
            chk(mdc === e_mdc, "R6 mdc", {31'b0, mdc}, {31'b0, e_mdc});
            chk(mdio_oe === e_oe, "R5 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            chk(mdio_out === e_out, "R4 mdio_out", {31'b0, mdio_out}, {31'b0, e_out});
            if (!mdio_oe) chk(mdio_out === 1'b0, "R9 quiet out", {31'b0, mdio_out}, 32'h0);
            if (m_busy && m_isread && b >= 48) mdio_in <= phy_val[15 - (b - 48)];
            else if (m_busy && m_isread && b == 47) mdio_in <= 1'b0;
            else mdio_in <= 1'b1;
        end
    end

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(rd_data === 32'h0, "R8 reset rd_data", rd_data, 32'h0);
        chk({mdc, mdio_oe, mdio_out} === 3'b000, "R8 reset pins", {29'b0, mdc, mdio_oe, mdio_out}, 32'h0);

        // R2 + R6: PHY write, flag held then cleared, frame length
        reg_write(32'h800B_A5C3);
        chk(rd_data[31] === 1'b1, "R2 flag busy", rd_data, 32'h800B_A5C3);
        cnt = 0;
        while (rd_data[31] === 1'b1 && cnt < FLEN + 10) begin cnt++; @(negedge clk); end
        chk(cnt == FLEN, "R6 frame length", cnt, FLEN);
        chk(rd_data === 32'h000B_A5C3, "R2 write done", rd_data, 32'h000B_A5C3);

        // R1: unused bits masked
        reg_write(32'hFFFF_1234);
        chk(rd_data === 32'h801F_1234, "R1 masking", rd_data, 32'h801F_1234);
        wait_idle();
        chk(rd_data === 32'h001F_1234, "R1 after write", rd_data, 32'h001F_1234);

        // R3 + R5: read, edge bits set
        phy_val = 16'h8001;
        reg_write(32'h0002_0000);
        wait_idle();
        chk(rd_data === 32'h8002_8001, "R3 read 8001", rd_data, 32'h8002_8001);

        // R7: write in middle of read ignored
        phy_val = 16'h5A3C;
        reg_write(32'h0015_0000);
        repeat (FLEN / 2) @(negedge clk);
        reg_write(32'h8000_FFFF);
        wait_idle();
        chk(rd_data === 32'h8015_5A3C, "R7 mid-frame write ignored", rd_data, 32'h8015_5A3C);

        // R7: write on the completion edge ignored, next cycle accepted
        phy_val = 16'hC3A5;
        reg_write(32'h0007_0000);
        while (m_k != FLEN - 1) @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h8000_1111;
        @(negedge clk);
        chk(rd_data === 32'h8007_C3A5, "R7 completion-edge write ignored", rd_data, 32'h8007_C3A5);
        chk(mdc === 1'b0, "R7 no new frame", {31'b0, mdc}, 32'h0);
        wr_data = 32'h0009_00FF;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        chk(rd_data === 32'h0009_00FF, "R7 next-cycle write accepted", rd_data, 32'h0009_00FF);
        phy_val = 16'h0F0F;
        wait_idle();
        chk(rd_data === 32'h8009_0F0F, "R3 read after back-to-back", rd_data, 32'h8009_0F0F);

        // R4: write with alternating data
        reg_write(32'h801F_5555);
        wait_idle();
        chk(rd_data === 32'h001F_5555, "R4 write alt pattern", rd_data, 32'h001F_5555);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule